// File: doc/BRIEF.md
# I2C Target Address Matcher and Byte Receiver

This block is the bus-facing front end of an I2C target. It watches the clock line and the data line with the system clock. Both lines pass through a two-flop synchronizer and a short agreement filter. From the filtered lines it finds start, repeated start and stop conditions, and it reports the bus as busy between a start and the next stop. After each start it shifts in an address byte, most significant bit first. It compares that byte against a programmed own address, in either 7-bit or 10-bit form. It pulls the data line low in the ninth clock to acknowledge a match. It leaves the line released on a mismatch and then ignores the transfer until the next start or stop.

In a write, every received byte is acknowledged and handed to the host on a one-cycle strobe. In a read, the block takes a byte from the host, pulses `tx_load` at that moment, and shifts the byte out most significant bit first. It keeps sending bytes while the controller acknowledges them. In 10-bit mode the block also keeps a flag after a complete two-byte write match. With that flag set, a one-byte read header that follows a repeated start is enough to select the target. Only the data-line driver is an output; it is an open-drain enable where 1 pulls the line low. The block does not stretch the clock.

Top module: `i2c_tgt_rx`

## Requirements
- R1: Out of reset `sda_oe`, `bus_busy`, `rx_valid` and `tx_load` are all 0.
- R2: A falling data line while the clock line is high sets `bus_busy`. A rising data line while the clock line is high clears it.
- R3: A change on either line that lasts fewer system clocks than the filter length is ignored. A one-cycle low pulse on the data line during an idle bus does not set `bus_busy`.
- R4: With `addr_10b`=0, the first byte after a start matches when its bits 7:1 equal `own_addr[6:0]`. Bit 0 is the direction, where 1 means read. On a match the ninth clock is acknowledged (data line low). With direction 0, each later byte is acknowledged and appears on `rx_byte` with a one-cycle `rx_valid`, first received bit in bit 7.
- R5: On an address mismatch the ninth clock is left released (NACK). `sda_oe` then stays 0 and `rx_valid` stays 0 until the next start or stop.
- R6: In a matched read, `tx_byte` is captured at the falling clock that ends the acknowledge slot, and `tx_load` pulses for one cycle. The captured byte goes out bit 7 first, one bit per clock. After a controller ACK (data line low in the ninth clock) the next byte is captured the same way.
- R7: After a controller NACK in a read, the target keeps the data line released for every following clock until a start or stop.
- R8: With `addr_10b`=1, a write header `11110`,`own_addr[9:8]`,`0` is acknowledged. A following byte equal to `own_addr[7:0]` is acknowledged and selects the target for writing as in R4.
- R9: In 10-bit mode, a second address byte that differs from `own_addr[7:0]` is not acknowledged, and the transfer is ignored as in R5.
- R10: After a full 10-bit write match, a repeated start followed by the read header `11110`,`own_addr[9:8]`,`1` is acknowledged and starts a read as in R6, with no low address byte.
- R11: The remembered 10-bit match is cleared by a stop and by a header whose upper bits differ. A read header with no remembered match is not acknowledged.
- R12: `sda_oe` changes only while the filtered clock line is low, apart from the release forced by a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| own_addr | input | 10 | Own address; only bits 6:0 are used in 7-bit mode |
| addr_10b | input | 1 | 1 selects 10-bit addressing |
| tx_byte | input | 8 | Byte to send in a read transfer |
| tx_load | output | 1 | One-cycle pulse when `tx_byte` is captured |
| rx_byte | output | 8 | Last byte received in a write transfer |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| bus_busy | output | 1 | High between a detected start and stop |

## Verification
Every result is due a fixed number of system clocks after the bus edge that causes it. That count is two synchronizer flops, the filter length, and one registered stage for the detector or the engine. With the default filter of three, this is about seven cycles. `bus_busy`, the acknowledge drive, `rx_valid` and `tx_load` all follow a clock or data edge by that amount. The bench moves a bus line only ten system clocks after the previous bus edge, and it samples the data line in the middle of the twenty-cycle clock-high phase. Every due result has therefore settled before it is read. One-cycle strobes are logged by a monitor on the falling system clock and compared once the scenario ends.

// File: rtl/i2c_tgt_pkg.sv
// Shared constants and the engine state type for the I2C target front end.
package i2c_tgt_pkg;
    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 10;
    localparam int LINE_N    = 2;   // clock line and data line
    localparam logic [4:0] HDR10_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,   // first address byte
        ST_ADDR2,   // low byte of a 10-bit address
        ST_ACK,     // target drives the acknowledge slot
        ST_WR,      // receiving data
        ST_RD,      // sending data
        ST_RDACK,   // controller acknowledge slot in a read
        ST_SKIP     // not addressed, wait for start or stop
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
// Synchronizes one bus line and passes a new level only after STAGES samples agree.
// Assumes the line idles high; the output resets high.
module i2c_line_filter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [1:0]        sync_q;
    logic [STAGES-1:0] hist_q;

    // two-flop synchronizer followed by a sample history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            hist_q <= {hist_q[STAGES-2:0], sync_q[1]};
        end
    end

    // output follows the history only when every sample agrees
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_out <= 1'b1;
        else if (&hist_q)
            line_out <= 1'b1;
        else if (~|hist_q)
            line_out <= 1'b0;
    end

    // R3: the output moves only after a full agreeing history
    a_r3_filtered_change: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out != $past(line_out)) |-> ($past(hist_q) == {STAGES{line_out}}));
endmodule

// File: rtl/i2c_bus_cond.sv
// Finds clock edges and start/stop conditions on the filtered lines and tracks bus busy.
// Assumes both inputs come from i2c_line_filter, so they are glitch free.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_busy
);
    logic scl_q, sda_q;

    // previous filtered levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

    // busy flag from start to stop
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_busy <= 1'b0;
        else if (start_det)
            bus_busy <= 1'b1;
        else if (stop_det)
            bus_busy <= 1'b0;
    end

    // R2: start marks the bus busy, stop frees it
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
    a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy);
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte engine: shifts address and data bits, matches 7/10-bit addresses, drives ACK and read data.
// Assumes one-cycle edge and condition strobes from i2c_bus_cond; SDA is changed only on a clock fall.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_f,
    input  logic                 sda_f,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 addr_10b,
    input  logic [BYTE_BITS-1:0] tx_byte,
    output logic                 sda_oe,
    output logic                 tx_load,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 rx_valid
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    tgt_state_e           state, nxt_q, after_ack;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] rx_sh, tx_sh;
    logic                 mem10, mack;
    logic                 take_ack, set_mem, clr_mem, hdr_ok, byte_end;

    assign hdr_ok   = (rx_sh[7:3] == HDR10_PREFIX) && (rx_sh[2:1] == own_addr[9:8]);
    assign byte_end = scl_fall && (cnt == LAST_BIT);

    // address decision for the byte that just completed
    always_comb begin
        take_ack  = 1'b0;
        after_ack = ST_SKIP;
        set_mem   = 1'b0;
        clr_mem   = 1'b0;
        case (state)
            ST_ADDR1: begin
                if (!addr_10b) begin
                    if (rx_sh[7:1] == own_addr[6:0]) begin
                        take_ack  = 1'b1;
                        after_ack = rx_sh[0] ? ST_RD : ST_WR;
                    end
                end else if (hdr_ok && !rx_sh[0]) begin
                    take_ack  = 1'b1;
                    after_ack = ST_ADDR2;
                    clr_mem   = 1'b1;
                end else if (hdr_ok && mem10) begin
                    take_ack  = 1'b1;
                    after_ack = ST_RD;
                end else if (!hdr_ok) begin
                    clr_mem   = 1'b1;
                end
            end
            ST_ADDR2: begin
                if (rx_sh == own_addr[7:0]) begin
                    take_ack  = 1'b1;
                    after_ack = ST_WR;
                    set_mem   = 1'b1;
                end
            end
            ST_WR: begin
                take_ack  = 1'b1;
                after_ack = ST_WR;
            end
            default: ;
        endcase
    end

    // engine state, shifters and line driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            nxt_q    <= ST_IDLE;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            sda_oe   <= 1'b0;
            tx_load  <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            mem10    <= 1'b0;
            mack     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                mem10  <= 1'b0;
                cnt    <= '0;
            end else if (start_det) begin
                state  <= ST_ADDR1;
                sda_oe <= 1'b0;
                cnt    <= '0;
            end else begin
                case (state)
                    ST_ADDR1, ST_ADDR2, ST_WR: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_BITS-2:0], sda_f};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (byte_end) begin
                            cnt <= '0;
                            if (take_ack) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                nxt_q  <= after_ack;
                            end else begin
                                state  <= ST_SKIP;
                            end
                            if (state == ST_WR) begin
                                rx_byte  <= rx_sh;
                                rx_valid <= 1'b1;
                            end
                            if (set_mem) mem10 <= 1'b1;
                            if (clr_mem) mem10 <= 1'b0;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state <= nxt_q;
                            if (nxt_q == ST_RD) begin
                                tx_sh   <= tx_byte;
                                sda_oe  <= ~tx_byte[BYTE_BITS-1];
                                tx_load <= 1'b1;
                            end else begin
                                sda_oe  <= 1'b0;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + CNT_W'(1);
                        end else if (byte_end) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            state  <= ST_RDACK;
                        end else if (scl_fall) begin
                            tx_sh  <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_BITS-2];
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_f;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx_sh   <= tx_byte;
                                sda_oe  <= ~tx_byte[BYTE_BITS-1];
                                tx_load <= 1'b1;
                                state   <= ST_RD;
                            end else begin
                                state   <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12: the driver holds still through a clock-high phase
    a_r12_sda_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));
    // R5: R7: an ignored transfer never pulls the line
    a_r5_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);
    // R4: a data strobe comes only with the acknowledge of a write byte
    a_r4_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state == ST_ACK && sda_oe));
    // R11: stop forgets the 10-bit match
    a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !mem10);
endmodule

// File: rtl/i2c_tgt_rx.sv
// Top of the I2C target front end: line filters, condition detector and byte engine.
// Assumes clk runs many times faster than the bus clock; sda_oe drives an open-drain pad.
module i2c_tgt_rx
    import i2c_tgt_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_oe,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 addr_10b,
    input  logic [BYTE_BITS-1:0] tx_byte,
    output logic                 tx_load,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 bus_busy
);
    logic [LINE_N-1:0] raw_lines, filt_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {scl_in, sda_in};

    // one filter per bus line
    for (genvar gi = 0; gi < LINE_N; gi++) begin : g_line
        i2c_line_filter #(.STAGES(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[gi]),
            .line_out (filt_lines[gi])
        );
    end

    i2c_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[1]),
        .sda_f     (filt_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_busy  (bus_busy)
    );

    i2c_tgt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[1]),
        .sda_f     (filt_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .addr_10b  (addr_10b),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .tx_load   (tx_load),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );
endmodule

// File: tb/test_i2c_tgt_rx.sv
`timescale 1ns/1ps
module test_i2c_tgt_rx;
    localparam int Q = 10;   // system clocks between a bus edge and the next line change
    localparam int H = 20;   // system clocks of clock-high phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic [9:0] own_addr = 10'h000;
    logic       addr_10b = 1'b0;
    logic [7:0] tx_q [0:3];
    int         tx_idx = 0;
    logic [7:0] tx_byte;
    logic       sda_oe, tx_load, rx_valid, bus_busy;
    logic [7:0] rx_byte;
    wire        sda_bus = ~(m_sda_low | sda_oe);

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    logic [7:0] rx_log [0:15];
    int rx_cnt = 0, load_cnt = 0, oe_cnt = 0, hold_viol = 0;
    logic scl_prev = 1'b1, oe_prev = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign tx_byte = tx_q[tx_idx & 3];

    i2c_tgt_rx i_i2c_tgt_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .own_addr(own_addr), .addr_10b(addr_10b), .tx_byte(tx_byte), .tx_load(tx_load),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .bus_busy(bus_busy)
    );

    // output monitor away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rx_valid) begin
            rx_log[rx_cnt & 15] <= rx_byte;
            rx_cnt <= rx_cnt + 1;
        end
        if (tx_load) begin
            load_cnt <= load_cnt + 1;
            tx_idx <= tx_idx + 1;
        end
        if (sda_oe) oe_cnt <= oe_cnt + 1;
        if (m_scl && scl_prev && (sda_oe != oe_prev)) hold_viol <= hold_viol + 1;
        scl_prev <= m_scl;
        oe_prev  <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_scl = 1'b1; wclk(Q);
        m_sda_low = 1'b1; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic m_rstart();
        m_sda_low = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda_low = 1'b1; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda_low = 1'b0; wclk(Q);
    endtask

    task automatic m_bit(input logic b, output logic s);
        m_sda_low = ~b; wclk(Q);
        m_scl = 1'b1; wclk(H/2);
        s = sda_bus; wclk(H/2);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, s);
            d = {d[6:0], s};
        end
        m_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 bus_busy after reset", int'(bus_busy), 0);
        chk("R1 rx_valid after reset", int'(rx_valid), 0);
        chk("R1 tx_load after reset", int'(tx_load), 0);
    endtask

    task automatic t_glitch();
        m_sda_low = 1'b1; wclk(1); m_sda_low = 1'b0; wclk(3 * Q);
        chk("R3 short data pulse leaves bus idle", int'(bus_busy), 0);
    endtask

    task automatic t_busy();
        m_start();
        chk("R2 busy after start", int'(bus_busy), 1);
        m_stop();
        chk("R2 idle after stop", int'(bus_busy), 0);
    endtask

    task automatic t_write7();
        logic a;
        int rx0 = rx_cnt;
        addr_10b = 1'b0; own_addr = 10'h02A;
        m_start();
        m_wbyte({7'h2A, 1'b0}, a); chk("R4 7-bit address ack", int'(a), 1);
        m_wbyte(8'hA5, a);         chk("R4 data byte 1 ack", int'(a), 1);
        m_wbyte(8'h3C, a);         chk("R4 data byte 2 ack", int'(a), 1);
        m_stop();
        chk("R4 strobe count", rx_cnt - rx0, 2);
        chk("R4 byte 1 value", int'(rx_log[rx0 & 15]), 'hA5);
        chk("R4 byte 2 value", int'(rx_log[(rx0 + 1) & 15]), 'h3C);
    endtask

    task automatic t_miss7();
        logic a;
        int rx0 = rx_cnt, oe0 = oe_cnt;
        m_start();
        m_wbyte({7'h2B, 1'b0}, a); chk("R5 mismatch nack", int'(a), 0);
        m_wbyte(8'h00, a);         chk("R5 later byte nack", int'(a), 0);
        m_stop();
        chk("R5 no strobe", rx_cnt - rx0, 0);
        chk("R5 line never driven", oe_cnt - oe0, 0);
    endtask

    task automatic t_read7();
        logic a, s;
        logic [7:0] d;
        int ld0 = load_cnt, oe0;
        tx_q[tx_idx & 3] = 8'h96; tx_q[(tx_idx + 1) & 3] = 8'h5A;
        m_start();
        m_wbyte({7'h2A, 1'b1}, a); chk("R6 read address ack", int'(a), 1);
        m_rbyte(1'b1, d);          chk("R6 read byte 1", int'(d), 'h96);
        m_rbyte(1'b0, d);          chk("R6 read byte 2", int'(d), 'h5A);
        chk("R6 load pulses", load_cnt - ld0, 2);
        oe0 = oe_cnt;
        for (int i = 0; i < 9; i++) m_bit(1'b1, s);
        chk("R7 released after nack", oe_cnt - oe0, 0);
        m_stop();
    endtask

    task automatic t_write10();
        logic a;
        int rx0 = rx_cnt;
        addr_10b = 1'b1; own_addr = 10'h2C7;
        m_start();
        m_wbyte(8'hF4, a); chk("R8 header ack", int'(a), 1);
        m_wbyte(8'hC7, a); chk("R8 low byte ack", int'(a), 1);
        m_wbyte(8'h81, a); chk("R8 data ack", int'(a), 1);
        m_stop();
        chk("R8 strobe count", rx_cnt - rx0, 1);
        chk("R8 data value", int'(rx_log[rx0 & 15]), 'h81);
    endtask

    task automatic t_bad10();
        logic a;
        int rx0 = rx_cnt;
        m_start();
        m_wbyte(8'hF4, a); chk("R9 header ack", int'(a), 1);
        m_wbyte(8'hC6, a); chk("R9 wrong low byte nack", int'(a), 0);
        m_wbyte(8'h55, a); chk("R9 later byte nack", int'(a), 0);
        m_stop();
        chk("R9 no strobe", rx_cnt - rx0, 0);
    endtask

    task automatic t_read10();
        logic a;
        logic [7:0] d;
        tx_q[tx_idx & 3] = 8'hE1;
        m_start();
        m_wbyte(8'hF4, a); chk("R10 header ack", int'(a), 1);
        m_wbyte(8'hC7, a); chk("R10 low byte ack", int'(a), 1);
        m_rstart();
        m_wbyte(8'hF5, a); chk("R10 read header ack", int'(a), 1);
        m_rbyte(1'b0, d);  chk("R10 read data", int'(d), 'hE1);
        m_stop();
    endtask

    task automatic t_forget10();
        logic a;
        m_start();
        m_wbyte(8'hF5, a); chk("R11 read header after stop nack", int'(a), 0);
        m_stop();
        m_start();
        m_wbyte(8'hF4, a); chk("R11 header ack", int'(a), 1);
        m_wbyte(8'hC7, a); chk("R11 low byte ack", int'(a), 1);
        m_rstart();
        m_wbyte(8'hF2, a); chk("R11 other header nack", int'(a), 0);
        m_rstart();
        m_wbyte(8'hF5, a); chk("R11 read header after other nack", int'(a), 0);
        m_stop();
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) tx_q[i] = 8'h00;
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        t_reset();
        wclk(10);
        t_glitch();
        t_busy();
        t_write7();
        t_miss7();
        t_read7();
        t_write10();
        t_bad10();
        t_read10();
        t_forget10();
        chk("R12 no driver change during clock high", hold_viol, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule